// File: doc/BRIEF.md
# Core Voltage Scaling Control Register

This block holds the software-visible controls for the core voltage range and for the booster stages that the regulator needs at the two upper ranges. Software reaches it through a minimal register port. The address decode is done outside the block, so a write is a one-cycle strobe with its data. Each write carries a secure attribute and a privileged attribute. A write is accepted only when those attributes satisfy the security and privilege configuration inputs. A write that is not accepted changes nothing and raises a one-cycle error pulse.

The block drives the selected range code, the main booster enable, the USB supply enable and the USB booster enable. It also drives three hardware-owned ready flags. Each booster has its own startup counter, and its ready flag rises only after that startup time has passed. The voltage-ready flag follows a level comparator that reports whether the core supply has reached the selected range. A stop-mode entry pulse clears both booster enables. A lock input stops software from selecting the top-performance range.

Top module: `vscale_ctrl`

## Requirements
- R1: After reset every control field, every ready flag, `acc_err` and `bus_rdata` are 0.
- R2: An accepted write loads the range code from data bits [1:0], where 0 is the lowest-power range, 1 and 2 are the intermediate ranges and 3 is the highest-frequency range. The same write loads the booster enable from bit 2, the USB supply enable from bit 3 and the USB booster enable from bit 4. Reads return those fields at the same positions, with voltage-ready at bit 8, booster-ready at bit 9 and USB-booster-ready at bit 10. All other bits read 0.
- R3: While `range1_lock` is 1, a write whose bits [1:0] equal 3 is rejected as a whole, and the range code keeps its old value.
- R4: While `cfg_clk_sec` is 1, a write with `bus_secure` = 0 is rejected.
- R5: A write with `bus_priv` = 0 is rejected when (`cfg_clk_sec` = 1 and `cfg_sec_priv` = 1) or when (`cfg_clk_sec` = 0 and `cfg_ns_priv` = 1).
- R6: In the cycle after `stop_entry` is high, both booster enables are 0. This holds even when a write in the same cycle sets them. The other fields of that write still take effect.
- R7: A booster ready flag rises exactly STARTUP_CYCLES cycles after its enable is first seen as 1. Its counter restarts from zero each time the enable is cleared and set again.
- R8: A booster ready flag is 0 in every cycle in which its enable is 0, including the first cycle after the enable clears.
- R9: `acc_err` is 1 for exactly the cycle after a rejected write, and is 0 otherwise.
- R10: `volt_rdy` shows `vcore_ok` as sampled at the previous clock edge. It is forced to 0 in the cycle after an accepted write changes the range code.
- R11: Write data bits other than [4:0] are ignored. In particular, the ready flags cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DW | Write data |
| bus_secure | input | 1 | Write is a secure access |
| bus_priv | input | 1 | Write is a privileged access |
| bus_rdata | output | DW | Register read value |
| cfg_clk_sec | input | 1 | Clock controls are secure-only |
| cfg_sec_priv | input | 1 | Privileged-only in the secure configuration |
| cfg_ns_priv | input | 1 | Privileged-only in the non-secure configuration |
| range1_lock | input | 1 | Vetoes selection of range code 3 |
| stop_entry | input | 1 | Stop-mode entry pulse |
| vcore_ok | input | 1 | Comparator: core supply at or above the selected level |
| range_sel | output | 2 | Selected range code |
| boost_en | output | 1 | Main booster enable |
| usb_pwr_en | output | 1 | USB supply enable |
| usb_boost_en | output | 1 | USB booster enable |
| volt_rdy | output | 1 | Core voltage ready flag |
| boost_rdy | output | 1 | Main booster ready flag |
| usb_boost_rdy | output | 1 | USB booster ready flag |
| acc_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The assertions assume that every input is synchronous to `clk` and stable across the sampling edge. They also assume that `vcore_ok` is already resynchronised, and that a write is a single-cycle strobe. The bench keeps to these assumptions by changing every input only on the falling edge. Random stimulus writes infrequently enough that the boosters often stay enabled for longer than the startup time. The security configuration is biased toward permissive settings so that accepted and rejected writes are both common.

// File: rtl/vscale_pkg.sv
package vscale_pkg;
   localparam int RANGE_LSB    = 0;
   localparam int BOOST_BIT    = 2;
   localparam int USBPWR_BIT   = 3;
   localparam int USBBOOST_BIT = 4;
   localparam int VRDY_BIT     = 8;
   localparam int BRDY_BIT     = 9;
   localparam int UBRDY_BIT    = 10;
   localparam int MIN_DW       = UBRDY_BIT + 1;

   typedef enum logic [1:0] {
      RANGE_LOWPWR = 2'd0,
      RANGE_LOWMID = 2'd1,
      RANGE_HIGHMID = 2'd2,
      RANGE_TOPFREQ = 2'd3
   } vrange_e;

   typedef struct packed {
      logic    usb_boost;
      logic    usb_pwr;
      logic    boost;
      vrange_e range;
   } vctrl_t;
endpackage

// File: rtl/vscale_wguard.sv
module vscale_wguard
   import vscale_pkg::*;
(
   input  logic       we,
   input  logic [1:0] wr_range,
   input  logic       secure,
   input  logic       priv,
   input  logic       clk_sec,
   input  logic       sec_priv,
   input  logic       ns_priv,
   input  logic       lock,
   output logic       wr_ok,
   output logic       wr_rej
);
   logic sec_fail, priv_fail, lock_fail, any_fail;

   always_comb begin
      sec_fail  = clk_sec && !secure;
      priv_fail = !priv && ((clk_sec && sec_priv) || (!clk_sec && ns_priv));
      lock_fail = lock && (vrange_e'(wr_range) == RANGE_TOPFREQ);
      any_fail  = sec_fail || priv_fail || lock_fail;
      wr_ok     = we && !any_fail;
      wr_rej    = we && any_fail;
   end

   always_comb begin
      a_excl_r9: assert (!(wr_ok && wr_rej));
   end
endmodule

// File: rtl/vscale_boost_timer.sv
module vscale_boost_timer #(
   parameter int CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic rdy
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("vscale_boost_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!en)        cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign rdy = en && (cnt_q == LAST);

   p_rise_after_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> $past(en));
   p_no_cnt_past_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   p_drop_with_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !rdy);
endmodule

// File: rtl/vscale_ctrl.sv
module vscale_ctrl
   import vscale_pkg::*;
#(
   parameter int DW             = 32,
   parameter int STARTUP_CYCLES = 16,
   parameter int USB_PRESENT    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_secure,
   input  logic          bus_priv,
   output logic [DW-1:0] bus_rdata,
   input  logic          cfg_clk_sec,
   input  logic          cfg_sec_priv,
   input  logic          cfg_ns_priv,
   input  logic          range1_lock,
   input  logic          stop_entry,
   input  logic          vcore_ok,
   output logic [1:0]    range_sel,
   output logic          boost_en,
   output logic          usb_pwr_en,
   output logic          usb_boost_en,
   output logic          volt_rdy,
   output logic          boost_rdy,
   output logic          usb_boost_rdy,
   output logic          acc_err
);
   localparam logic USB_ON = (USB_PRESENT != 0);

   if (DW < MIN_DW) begin : g_bad_dw
      $error("vscale_ctrl: DW too narrow for the register layout");
   end
   if (STARTUP_CYCLES < 1) begin : g_bad_startup
      $error("vscale_ctrl: STARTUP_CYCLES must be at least 1");
   end

   logic   wr_ok, wr_rej, range_chg;
   vctrl_t ctrl_q, ctrl_d;
   logic   vrdy_q, err_q;
   logic   brdy, ubrdy;

   vscale_wguard u_guard (
      .we       (bus_we),
      .wr_range (bus_wdata[RANGE_LSB +: 2]),
      .secure   (bus_secure),
      .priv     (bus_priv),
      .clk_sec  (cfg_clk_sec),
      .sec_priv (cfg_sec_priv),
      .ns_priv  (cfg_ns_priv),
      .lock     (range1_lock),
      .wr_ok    (wr_ok),
      .wr_rej   (wr_rej)
   );

   always_comb begin
      ctrl_d    = ctrl_q;
      range_chg = 1'b0;
      if (wr_ok) begin
         ctrl_d.range     = vrange_e'(bus_wdata[RANGE_LSB +: 2]);
         ctrl_d.boost     = bus_wdata[BOOST_BIT];
         ctrl_d.usb_pwr   = bus_wdata[USBPWR_BIT] & USB_ON;
         ctrl_d.usb_boost = bus_wdata[USBBOOST_BIT] & USB_ON;
         range_chg        = (bus_wdata[RANGE_LSB +: 2] != ctrl_q.range);
      end
      if (stop_entry) begin
         ctrl_d.boost     = 1'b0;
         ctrl_d.usb_boost = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         vrdy_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         ctrl_q <= ctrl_d;
         vrdy_q <= vcore_ok && !range_chg;
         err_q  <= wr_rej;
      end
   end

   vscale_boost_timer #(.CYCLES(STARTUP_CYCLES)) u_main_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctrl_q.boost),
      .rdy   (brdy)
   );

   if (USB_PRESENT != 0) begin : g_usb
      vscale_boost_timer #(.CYCLES(STARTUP_CYCLES)) u_usb_timer (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (ctrl_q.usb_boost),
         .rdy   (ubrdy)
      );
   end else begin : g_no_usb
      assign ubrdy = 1'b0;
   end

   assign range_sel     = ctrl_q.range;
   assign boost_en      = ctrl_q.boost;
   assign usb_pwr_en    = ctrl_q.usb_pwr;
   assign usb_boost_en  = ctrl_q.usb_boost;
   assign volt_rdy      = vrdy_q;
   assign boost_rdy     = brdy;
   assign usb_boost_rdy = ubrdy;
   assign acc_err       = err_q;

   always_comb begin
      bus_rdata                      = '0;
      bus_rdata[RANGE_LSB +: 2]      = ctrl_q.range;
      bus_rdata[BOOST_BIT]           = ctrl_q.boost;
      bus_rdata[USBPWR_BIT]          = ctrl_q.usb_pwr;
      bus_rdata[USBBOOST_BIT]        = ctrl_q.usb_boost;
      bus_rdata[VRDY_BIT]            = vrdy_q;
      bus_rdata[BRDY_BIT]            = brdy;
      bus_rdata[UBRDY_BIT]           = ubrdy;
   end

   p_lock_veto_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && range1_lock && bus_wdata[1:0] == 2'd3 && range_sel != 2'd3)
      |=> range_sel != 2'd3);
   p_nonsecure_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && cfg_clk_sec && !bus_secure)
      |=> $stable(range_sel) && $stable(usb_pwr_en) && acc_err);
   p_unpriv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_priv && ((cfg_clk_sec && cfg_sec_priv) || (!cfg_clk_sec && cfg_ns_priv)))
      |=> $stable(range_sel) && $stable(usb_pwr_en) && acc_err);
   p_stop_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_entry |=> !boost_en && !usb_boost_en);
   p_err_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> $past(bus_we));
   p_vrdy_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
      volt_rdy |-> $past(vcore_ok));
   p_vrdy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (range_sel != $past(range_sel)) |-> !volt_rdy);
endmodule

// File: tb/vscale_ctrl_bench.sv
`timescale 1ns/1ps
module vscale_ctrl_bench;
   localparam int T = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        we, sec, priv, cs, sp, np, lock, stop, vok;
   logic [31:0] wd;
   logic [31:0] rdata;
   logic [1:0]  range_sel;
   logic        boost_en, usb_pwr_en, usb_boost_en, volt_rdy, boost_rdy, usb_boost_rdy, acc_err;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [1:0] m_range;
   logic       m_boost, m_upwr, m_uboost, m_vrdy, m_err;
   int         m_bcnt, m_ucnt;

   always #2.5 clk = ~clk;

   vscale_ctrl #(.DW(32), .STARTUP_CYCLES(T), .USB_PRESENT(1)) u_vscale_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_wdata(wd), .bus_secure(sec),
      .bus_priv(priv), .bus_rdata(rdata), .cfg_clk_sec(cs), .cfg_sec_priv(sp),
      .cfg_ns_priv(np), .range1_lock(lock), .stop_entry(stop), .vcore_ok(vok),
      .range_sel(range_sel), .boost_en(boost_en), .usb_pwr_en(usb_pwr_en),
      .usb_boost_en(usb_boost_en), .volt_rdy(volt_rdy), .boost_rdy(boost_rdy),
      .usb_boost_rdy(usb_boost_rdy), .acc_err(acc_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic rej_now();
      logic deny;
      deny = (cs && !sec) || (!priv && ((cs && sp) || (!cs && np))) ||
             (lock && wd[1:0] == 2'd3);
      return we && deny;
   endfunction

   function automatic logic [31:0] exp_rdata();
      logic [31:0] r;
      r = '0;
      r[1:0] = m_range; r[2] = m_boost; r[3] = m_upwr; r[4] = m_uboost;
      r[8] = m_vrdy; r[9] = m_boost && m_bcnt == T; r[10] = m_uboost && m_ucnt == T;
      return r;
   endfunction

   task automatic model_edge();
      logic ok, chg;
      ok  = we && !rej_now();
      chg = ok && (wd[1:0] != m_range);
      m_bcnt = m_boost  ? ((m_bcnt == T) ? T : m_bcnt + 1) : 0;
      m_ucnt = m_uboost ? ((m_ucnt == T) ? T : m_ucnt + 1) : 0;
      if (ok) begin
         m_range = wd[1:0]; m_boost = wd[2]; m_upwr = wd[3]; m_uboost = wd[4];
      end
      if (stop) begin
         m_boost = 1'b0; m_uboost = 1'b0;
      end
      m_vrdy = vok && !chg;
      m_err  = rej_now();
   endtask

   task automatic compare_all();
      chk("R2 range", {30'b0, range_sel}, {30'b0, m_range});
      chk("R6 boost_en", {31'b0, boost_en}, {31'b0, m_boost});
      chk("R2 usb_pwr_en", {31'b0, usb_pwr_en}, {31'b0, m_upwr});
      chk("R6 usb_boost_en", {31'b0, usb_boost_en}, {31'b0, m_uboost});
      chk("R7 boost_rdy", {31'b0, boost_rdy}, {31'b0, m_boost && m_bcnt == T});
      chk("R8 usb_boost_rdy", {31'b0, usb_boost_rdy}, {31'b0, m_uboost && m_ucnt == T});
      chk("R10 volt_rdy", {31'b0, volt_rdy}, {31'b0, m_vrdy});
      chk("R9 acc_err", {31'b0, acc_err}, {31'b0, m_err});
      chk("R11 rdata", rdata, exp_rdata());
   endtask

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
      we = 1'b0; stop = 1'b0;
   endtask

   task automatic open_cfg();
      sec = 1'b1; priv = 1'b1; cs = 1'b0; sp = 1'b0; np = 1'b0; lock = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; we = 1'b0; wd = '0; stop = 1'b0; vok = 1'b0;
      open_cfg();
      m_range = '0; m_boost = 0; m_upwr = 0; m_uboost = 0; m_vrdy = 0; m_err = 0;
      m_bcnt = 0; m_ucnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset rdata", rdata, 32'h0);
      chk("R1 reset outputs", {23'b0, range_sel, boost_en, usb_pwr_en, usb_boost_en,
          volt_rdy, boost_rdy, usb_boost_rdy, acc_err}, 32'h0);

      // R2 / R7: select range 2 with both boosters, then wait out the startup time
      we = 1'b1; wd = 32'h0000_0016; step();
      chk("R2 range code 2", {30'b0, range_sel}, 32'd2);
      for (int i = 1; i < T; i++) begin
         step();
         chk("R7 not ready early", {31'b0, boost_rdy}, 32'd0);
      end
      step();
      chk("R7 ready at startup time", {31'b0, boost_rdy}, 32'd1);
      chk("R7 usb ready at startup time", {31'b0, usb_boost_rdy}, 32'd1);

      // R3: code 3 vetoed under lock, whole write dropped
      lock = 1'b1; we = 1'b1; wd = 32'h0000_0003; step();
      chk("R3 range kept", {30'b0, range_sel}, 32'd2);
      chk("R3 boost kept", {31'b0, boost_en}, 32'd1);
      chk("R9 error pulse", {31'b0, acc_err}, 32'd1);
      step();
      chk("R9 pulse ends", {31'b0, acc_err}, 32'd0);
      lock = 1'b0;

      // R4: non-secure write with secure clock config
      cs = 1'b1; sec = 1'b0; we = 1'b1; wd = 32'h0000_0001; step();
      chk("R4 range kept", {30'b0, range_sel}, 32'd2);
      open_cfg();

      // R5: unprivileged with non-secure privilege bit set
      np = 1'b1; priv = 1'b0; we = 1'b1; wd = 32'h0000_0009; step();
      chk("R5 usb_pwr kept", {31'b0, usb_pwr_en}, 32'd0);
      open_cfg();

      // R6 / R8: stop wins over a write that sets the boosters
      stop = 1'b1; we = 1'b1; wd = 32'h0000_001D; step();
      chk("R6 boost cleared", {31'b0, boost_en}, 32'd0);
      chk("R6 usb_pwr from same write", {31'b0, usb_pwr_en}, 32'd1);
      chk("R8 ready dropped", {31'b0, boost_rdy}, 32'd0);
      chk("R6 range from same write", {30'b0, range_sel}, 32'd1);

      // R10: range change forces volt_rdy low for one cycle
      vok = 1'b1; step(); step();
      chk("R10 tracks comparator", {31'b0, volt_rdy}, 32'd1);
      we = 1'b1; wd = 32'h0000_0000; step();
      chk("R10 drop on range change", {31'b0, volt_rdy}, 32'd0);
      step();
      chk("R10 reasserts", {31'b0, volt_rdy}, 32'd1);

      // R11: ready bits not writable
      we = 1'b1; wd = 32'hFFFF_FF00; step();
      chk("R11 ready bits unwritten", rdata, 32'h0000_0100);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         we   = ($urandom % 8) == 0;
         wd   = $urandom;
         stop = ($urandom % 40) == 0;
         vok  = ($urandom % 4) != 0;
         lock = $urandom % 2;
         cs   = ($urandom % 4) == 0;
         sec  = ($urandom % 4) != 0;
         priv = ($urandom % 4) != 0;
         sp   = $urandom % 2;
         np   = ($urandom % 4) == 0;
         step();
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule